// File: doc/BRIEF.md
# Processor Reset-Sideband Signal Controller

This block drives two active-low sideband outputs toward a host processor. The first masks address line 20. It is active only when a software-held alternate gate bit and a gate level from an external keyboard microcontroller are both clear. The second is a fixed-length initialization pulse. Any of several request events starts this pulse, and so does a one-shot software write. A copy of the pulse, identical cycle for cycle, appears on a second output for a different signalling domain.

The pulse length is counted in block clocks, which are PCI-domain clocks. While a stop-clock indication is active, the count is frozen. A request made while stop-clock is active is held pending, and its pulse starts only after stop-clock is released. The keyboard-controller gate and the stop-clock input are asynchronous, so each passes through a two-stage synchronizer first. The register write path has no back-pressure: a write strobe is taken on every clock edge where it is high.

Top module: `cpu_sideband_ctl`

## Requirements
- R1: After reset the control register reads 0, `init_n` and `init_alt_n` are high, `busy` is low, and with the gate input low `a20_mask_n` is low.
- R2: `a20_mask_n` is low only when control register bit 1 is 0 and the synchronized gate input is 0. A write with bit 1 set drives it high from the next clock.
- R3: A change on `kbc_gate` appears on `a20_mask_n` after exactly two rising clock edges, and not after one.
- R4: A single-cycle event on any `init_evt` bit that is sampled at edge k sets the block pending. `init_n` then goes low after edge k+1 and stays low for exactly PULSE_LEN (16) clocks.
- R5: `init_alt_n` equals `init_n` in every cycle.
- R6: Writing 1 to control register bit 0 requests a pulse, with the same timing as an event. Bit 0 always reads back as 0, and the other bits read back as written.
- R7: Requests that arrive while a request is pending or a pulse is in progress merge into that single pulse. No second pulse follows.
- R8: A request made while synchronized stop-clock is high leaves `init_n` high and keeps it pending. The pulse, of full length, starts only after stop-clock falls.
- R9: If stop-clock is high for H synchronized cycles during a pulse, the count freezes and `init_n` stays low for PULSE_LEN + H clocks in one unbroken stretch.
- R10: `busy` is high from the clock after a request is accepted until the pulse ends. It falls in the same cycle that `init_n` returns high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock (PCI domain) |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_wr_en | input | 1 | Control register write strobe |
| cfg_wr_data | input | REG_W | Write data; bit 1 is the alternate A20 gate, bit 0 is the init request |
| cfg_rd_data | output | REG_W | Control register read value (bit 0 always 0) |
| kbc_gate | input | 1 | Asynchronous A20 gate level from keyboard controller |
| stop_clk | input | 1 | Asynchronous stop-clock indication, active high |
| init_evt | input | N_EVT | Synchronous initialization request events |
| a20_mask_n | output | 1 | Address-line-20 mask, active low |
| init_n | output | 1 | Initialization pulse, active low |
| init_alt_n | output | 1 | Mirror of init_n for a second signalling domain |
| busy | output | 1 | Request accepted and pulse not yet complete |

## Verification
The bench builds the block with N_EVT=3, PULSE_LEN=16 and SYNC_STAGES=2. With these values the full 16-clock pulse can be measured directly. The two-edge synchronizer latency can also be checked edge by edge. A 10-cycle stop-clock window fits wholly inside a pulse, which gives an exact expected length of 26. Using three event lines shows that separate event bits and the software request all merge into one pulse.

// File: rtl/sb_pkg.sv
package sb_pkg;
  // Field positions inside the control register; the mask gating decodes these.
  localparam int SB_INIT_BIT = 0;
  localparam int SB_A20_BIT  = 1;

  typedef enum logic [1:0] {
    SB_IDLE  = 2'd0,
    SB_PEND  = 2'd1,
    SB_PULSE = 2'd2
  } sb_state_e;
endpackage

// File: rtl/sb_sync.sv
module sb_sync #(
  parameter int STAGES = 2,
  parameter int W      = 1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] chain [STAGES];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < STAGES; i++) chain[i] <= '0;
    end else begin
      chain[0] <= d;
      for (int i = 1; i < STAGES; i++) chain[i] <= chain[i-1];
    end
  end

  assign q = chain[STAGES-1];
endmodule

// File: rtl/sb_port_reg.sv
module sb_port_reg
  import sb_pkg::*;
#(
  parameter int REG_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [REG_W-1:0] wr_data,
  output logic [REG_W-1:0] reg_q,
  output logic             alt_gate,
  output logic             init_strobe
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      reg_q <= '0;
    end else if (wr_en) begin
      reg_q              <= wr_data;
      reg_q[SB_INIT_BIT] <= 1'b0;   // self-clearing request bit never stored
    end
  end

  assign alt_gate    = reg_q[SB_A20_BIT];
  assign init_strobe = wr_en & wr_data[SB_INIT_BIT];
endmodule

// File: rtl/sb_init_pulse.sv
module sb_init_pulse
  import sb_pkg::*;
#(
  parameter int N_EVT     = 4,
  parameter int PULSE_LEN = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [N_EVT-1:0] evt,
  input  logic             sw_req,
  input  logic             stall,
  output logic             pulse_n,
  output logic             busy
);
  localparam int CNT_W = (PULSE_LEN > 1) ? $clog2(PULSE_LEN) : 1;
  localparam logic [CNT_W-1:0] LAST = CNT_W'(PULSE_LEN - 1);

  sb_state_e        state_q;
  logic [CNT_W-1:0] cnt_q;
  logic             req;

  assign req = (|evt) | sw_req;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= SB_IDLE;
      cnt_q   <= '0;
    end else begin
      unique case (state_q)
        SB_IDLE: if (req) state_q <= SB_PEND;
        SB_PEND: if (!stall) begin
          state_q <= SB_PULSE;
          cnt_q   <= '0;
        end
        SB_PULSE: if (!stall) begin
          if (cnt_q == LAST) state_q <= SB_IDLE;
          else               cnt_q   <= cnt_q + 1'b1;
        end
        default: state_q <= SB_IDLE;
      endcase
    end
  end

  assign pulse_n = (state_q != SB_PULSE);
  assign busy    = (state_q != SB_IDLE);
endmodule

// File: rtl/cpu_sideband_ctl.sv
module cpu_sideband_ctl
  import sb_pkg::*;
#(
  parameter int N_EVT       = 4,
  parameter int PULSE_LEN   = 16,
  parameter int SYNC_STAGES = 2,
  parameter int REG_W       = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cfg_wr_en,
  input  logic [REG_W-1:0] cfg_wr_data,
  output logic [REG_W-1:0] cfg_rd_data,
  input  logic             kbc_gate,
  input  logic             stop_clk,
  input  logic [N_EVT-1:0] init_evt,
  output logic             a20_mask_n,
  output logic             init_n,
  output logic             init_alt_n,
  output logic             busy
);
  logic [1:0] async_in;
  logic [1:0] async_sync;
  logic       kbc_sync;
  logic       stop_sync;
  logic       alt_gate;
  logic       sw_req;
  logic       pulse_n;

  assign async_in = {stop_clk, kbc_gate};

  sb_sync #(.STAGES(SYNC_STAGES), .W(2)) u_sync (
    .clk(clk), .rst_n(rst_n), .d(async_in), .q(async_sync)
  );
  assign kbc_sync  = async_sync[0];
  assign stop_sync = async_sync[1];

  sb_port_reg #(.REG_W(REG_W)) u_port (
    .clk(clk), .rst_n(rst_n), .wr_en(cfg_wr_en), .wr_data(cfg_wr_data),
    .reg_q(cfg_rd_data), .alt_gate(alt_gate), .init_strobe(sw_req)
  );

  sb_init_pulse #(.N_EVT(N_EVT), .PULSE_LEN(PULSE_LEN)) u_pulse (
    .clk(clk), .rst_n(rst_n), .evt(init_evt), .sw_req(sw_req),
    .stall(stop_sync), .pulse_n(pulse_n), .busy(busy)
  );

  // Mask is active low only when both gate sources are clear.
  assign a20_mask_n = alt_gate | kbc_sync;
  assign init_n     = pulse_n;
  assign init_alt_n = pulse_n;
endmodule

// File: rtl/sb_checker.sv
module sb_checker
  import sb_pkg::*;
#(
  parameter int PULSE_LEN = 16,
  parameter int REG_W     = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic             cfg_wr_en,
  input logic [REG_W-1:0] cfg_wr_data,
  input logic [REG_W-1:0] cfg_rd_data,
  input logic             a20_mask_n,
  input logic             init_n,
  input logic             init_alt_n,
  input logic             busy,
  input logic             stop_s
);
  int low_cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      low_cnt <= 0;
    else if (init_n) low_cnt <= 0;
    else             low_cnt <= low_cnt + 1;
  end

  assert_alt_mirror_R5: assert property (@(posedge clk) disable iff (!rst_n)
    init_alt_n == init_n);

  assert_gate_bit_unmasks_R2: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_wr_en && cfg_wr_data[SB_A20_BIT] |=> a20_mask_n);

  assert_req_bit_reads_zero_R6: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_rd_data[SB_INIT_BIT] == 1'b0);

  assert_idle_means_high_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> init_n);

  assert_pulse_after_busy_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(init_n) |-> $past(busy));

  assert_min_length_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(init_n) |-> low_cnt >= PULSE_LEN);

  assert_stall_holds_low_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !init_n && stop_s |=> !init_n);

  assert_stall_defers_R8: assert property (@(posedge clk) disable iff (!rst_n)
    busy && init_n && stop_s |=> init_n);
endmodule

bind cpu_sideband_ctl sb_checker #(.PULSE_LEN(PULSE_LEN), .REG_W(REG_W)) u_sb_checker (
  .clk(clk), .rst_n(rst_n), .cfg_wr_en(cfg_wr_en), .cfg_wr_data(cfg_wr_data),
  .cfg_rd_data(cfg_rd_data), .a20_mask_n(a20_mask_n), .init_n(init_n),
  .init_alt_n(init_alt_n), .busy(busy), .stop_s(stop_sync)
);

// File: tb/test_cpu_sideband_ctl.sv
module test_cpu_sideband_ctl;
  localparam int CLK_PERIOD = 10;
  localparam int N_EVT      = 3;
  localparam int PULSE_LEN  = 16;
  localparam int SYNC       = 2;
  localparam int REG_W      = 8;
  localparam int STALL_H    = 10;

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic             cfg_wr_en = 1'b0;
  logic [REG_W-1:0] cfg_wr_data = '0;
  logic [REG_W-1:0] cfg_rd_data;
  logic             kbc_gate = 1'b0;
  logic             stop_clk = 1'b0;
  logic [N_EVT-1:0] init_evt = '0;
  logic             a20_mask_n, init_n, init_alt_n, busy;

  int checks = 0;
  int fails  = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  cpu_sideband_ctl #(.N_EVT(N_EVT), .PULSE_LEN(PULSE_LEN), .SYNC_STAGES(SYNC),
                     .REG_W(REG_W)) i_cpu_sideband_ctl (
    .clk(clk), .rst_n(rst_n), .cfg_wr_en(cfg_wr_en), .cfg_wr_data(cfg_wr_data),
    .cfg_rd_data(cfg_rd_data), .kbc_gate(kbc_gate), .stop_clk(stop_clk),
    .init_evt(init_evt), .a20_mask_n(a20_mask_n), .init_n(init_n),
    .init_alt_n(init_alt_n), .busy(busy)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic wr(input logic [REG_W-1:0] d);
    @(negedge clk); cfg_wr_en = 1'b1; cfg_wr_data = d;
    @(negedge clk); cfg_wr_en = 1'b0; cfg_wr_data = '0;
  endtask

  task automatic fire(input int idx);
    @(negedge clk); init_evt[idx] = 1'b1;
    @(negedge clk); init_evt = '0;
  endtask

  // Count negedges until low, then the unbroken low run; alt compared each cycle.
  task automatic measure(output int delay, output int len);
    bit mirror_ok = 1'b1;
    bit busy_ok   = 1'b1;
    delay = 0; len = 0;
    while (init_n && delay < 40) begin
      @(negedge clk); delay++;
    end
    while (!init_n && len < 200) begin
      if (init_alt_n != init_n) mirror_ok = 1'b0;
      if (!busy) busy_ok = 1'b0;
      len++;
      @(negedge clk);
    end
    check(mirror_ok, "R5 alt mirrors init", int'(mirror_ok), 1);
    check(busy_ok, "R10 busy high while low", int'(busy_ok), 1);
    check(busy == 1'b0, "R10 busy falls with pulse end", int'(busy), 0);
  endtask

  task automatic t_reset();
    check(cfg_rd_data == '0, "R1 reg reset", int'(cfg_rd_data), 0);
    check(init_n == 1'b1, "R1 init_n high", int'(init_n), 1);
    check(init_alt_n == 1'b1, "R1 init_alt_n high", int'(init_alt_n), 1);
    check(busy == 1'b0, "R1 busy low", int'(busy), 0);
    check(a20_mask_n == 1'b0, "R1 mask active", int'(a20_mask_n), 0);
  endtask

  task automatic t_a20();
    // R3: latency of exactly two edges
    @(negedge clk); kbc_gate = 1'b1;
    @(negedge clk);
    check(a20_mask_n == 1'b0, "R3 not after one edge", int'(a20_mask_n), 0);
    @(negedge clk);
    check(a20_mask_n == 1'b1, "R3 after two edges", int'(a20_mask_n), 1);
    // R2 truth table
    wr(8'h02);
    check(a20_mask_n == 1'b1, "R2 bit1=1 gate=1", int'(a20_mask_n), 1);
    kbc_gate = 1'b0; repeat (3) @(negedge clk);
    check(a20_mask_n == 1'b1, "R2 bit1=1 gate=0", int'(a20_mask_n), 1);
    wr(8'h00);
    check(a20_mask_n == 1'b0, "R2 bit1=0 gate=0", int'(a20_mask_n), 0);
    kbc_gate = 1'b1; repeat (3) @(negedge clk);
    check(a20_mask_n == 1'b1, "R2 bit1=0 gate=1", int'(a20_mask_n), 1);
    kbc_gate = 1'b0; repeat (3) @(negedge clk);
  endtask

  task automatic t_event();
    int d, l;
    fire(1);
    check(busy == 1'b1 && init_n == 1'b1, "R10 pending busy", int'(busy), 1);
    measure(d, l);
    check(d == 1, "R4 pulse start", d, 1);
    check(l == PULSE_LEN, "R4 pulse length", l, PULSE_LEN);
  endtask

  task automatic t_sw();
    int d, l;
    wr(8'hA5);
    check(cfg_rd_data == 8'hA4, "R6 readback bit0 zero", int'(cfg_rd_data), 8'hA4);
    measure(d, l);
    check(d == 1, "R6 sw pulse start", d, 1);
    check(l == PULSE_LEN, "R6 sw pulse length", l, PULSE_LEN);
    wr(8'h00);
  endtask

  task automatic t_merge();
    int len = 0;
    bit ended = 1'b0;
    @(negedge clk); init_evt = 3'b001;
    @(negedge clk); init_evt = 3'b100;   // arrives while pending
    @(negedge clk); init_evt = '0;
    for (int i = 0; i < 60 && !ended; i++) begin
      if (!init_n) len++;
      else if (len > 0) ended = 1'b1;
      if (len == 3) init_evt = 3'b010; else init_evt = '0;
      cfg_wr_en = (len == 8); cfg_wr_data = (len == 8) ? 8'h01 : 8'h00;
      @(negedge clk);
    end
    init_evt = '0; cfg_wr_en = 1'b0; cfg_wr_data = '0;
    check(len == PULSE_LEN, "R7 merged length", len, PULSE_LEN);
    begin
      bit quiet = 1'b1;
      for (int i = 0; i < 30; i++) begin
        if (!init_n || busy) quiet = 1'b0;
        @(negedge clk);
      end
      check(quiet, "R7 no second pulse", int'(quiet), 1);
    end
  endtask

  task automatic t_stop_pending();
    int d, l;
    bit held = 1'b1;
    @(negedge clk); stop_clk = 1'b1;
    repeat (SYNC + 1) @(negedge clk);
    fire(0);
    for (int i = 0; i < 20; i++) begin
      if (!init_n || !busy) held = 1'b0;
      @(negedge clk);
    end
    check(held, "R8 deferred while stopped", int'(held), 1);
    stop_clk = 1'b0;
    measure(d, l);
    check(d == SYNC + 1, "R8 start after release", d, SYNC + 1);
    check(l == PULSE_LEN, "R8 full length", l, PULSE_LEN);
  endtask

  task automatic t_stop_mid();
    int len = 0, hold = 0;
    bit raised = 1'b0, ended = 1'b0;
    fire(2);
    for (int i = 0; i < 100 && !ended; i++) begin
      @(negedge clk);
      if (!init_n) len++;
      else if (len > 0) ended = 1'b1;
      if (len == 5 && !raised) begin stop_clk = 1'b1; raised = 1'b1; end
      else if (raised && stop_clk) begin
        hold++;
        if (hold == STALL_H) stop_clk = 1'b0;
      end
    end
    stop_clk = 1'b0;
    check(len == PULSE_LEN + STALL_H, "R9 stretched length", len, PULSE_LEN + STALL_H);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_a20();
    t_event();
    t_sw();
    t_merge();
    t_stop_pending();
    t_stop_mid();
    repeat (5) @(negedge clk);
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule